// File: doc/BRIEF.md
# Bubble-Squeezing Dual-Clock Write-Data Bridge

This block carries the write-data channel of an AXI-style bus from a master running on a slow clock to a slave running on a fast clock. Beats go into a 16-entry dual-clock buffer. The buffer's read and write pointers cross between the two domains as Gray codes, each through a two-flop synchroniser.

If the fast side took beats as soon as they arrived, it would empty the buffer partway through each burst. It would then sit idle while the slow master caught up, which leaves holes in the write-data stream that no downstream consumer can remove. To prevent this, the bridge holds back its fast-side valid until enough of the current burst is buffered. The threshold depends on the clock ratio and the burst length. Once released, the burst drains as one unbroken run of beats.

The master delivers each burst length (beats minus one) at its address handshake. The length goes through a separate 4-entry dual-clock queue, so the fast side knows the size of every burst, in order.

Top module: `wdb_squeeze_bridge`

## Requirements
- R1: After reset, `s_wvalid_o` is 0, `m_wready_o` is 1 and `m_len_ready_o` is 1.
- R2: Every beat written on the master side appears on the fast side once, in the same order, with its data and last flag unchanged.
- R3: The buffer holds 16 beats. While the fast side accepts nothing, the master can write 16 beats with `m_wready_o` high throughout. After the 16th beat, `m_wready_o` is 0.
- R4: Let R be `ratio_i` (fast frequency over slow frequency) and L the burst length, where L = `m_len_i` + 1. The first beat of a burst is not offered on the fast side until the master has written at least L − floor((L−1)/R) beats of that burst.
- R5: Once a burst is offered, `s_wvalid_o` stays high on every fast cycle until its last beat has transferred. No idle cycle appears between beats of a burst.
- R6: In the fast cycle after the transfer of a beat with `s_wlast_o` = 1, `s_wvalid_o` is 0.
- R7: The length queue holds 4 entries. After 4 lengths are accepted with no burst completed, `m_len_ready_o` is 0. It returns to 1 once bursts complete.
- R9: While `s_wvalid_o` is 1 and `s_wready_i` is 0, the next cycle keeps `s_wvalid_o` at 1, with `s_wdata_o` and `s_wlast_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk_i | input | 1 | Slow (master) clock |
| m_rst_ni | input | 1 | Slow-domain active-low asynchronous reset |
| m_len_valid_i | input | 1 | Burst length offered (address handshake) |
| m_len_ready_o | output | 1 | Length queue has room |
| m_len_i | input | LW | Burst length field, beats minus one |
| m_wvalid_i | input | 1 | Master write beat valid |
| m_wready_o | output | 1 | Buffer has room |
| m_wdata_i | input | DW | Master write data |
| m_wlast_i | input | 1 | Last beat of burst |
| s_clk_i | input | 1 | Fast (slave) clock |
| s_rst_ni | input | 1 | Fast-domain active-low asynchronous reset |
| ratio_i | input | RW | Static clock ratio; 0 is taken as 1 |
| s_wvalid_o | output | 1 | Beat of the released burst available |
| s_wready_i | input | 1 | Slave accepts beat |
| s_wdata_o | output | DW | Write data to slave |
| s_wlast_o | output | 1 | Last beat of burst |

## Verification
The bench samples on falling edges. On the master side, `m_wready_o` and `m_len_ready_o` are checked at the falling edge right after the accepting rising edge, because full flags come straight from the registered write pointer. On the fast side, the burst gate is a register, so the gap that must follow a last beat (R6) is checked one falling edge after the edge on which that beat transferred. The no-bubble rule (R5) is checked on every falling edge while a burst is open. The release threshold (R4) is checked at the first falling edge where a burst's valid is seen, against the count of master beats the driver has had accepted by then. Synchroniser delay only postpones that moment, so no fixed offset is assumed for it.

// File: rtl/wdb_pkg.sv
`timescale 1ns/1ps
package wdb_pkg;

  // beats to hold back before release: L - floor((L-1)/R)
  function automatic logic [7:0] squeeze_thresh(input logic [7:0] beats,
                                                input logic [7:0] ratio);
    logic [7:0] r;
    r = (ratio == 8'd0) ? 8'd1 : ratio;
    return beats - ((beats - 8'd1) / r);
  endfunction

endpackage

// File: rtl/wdb_sync.sv
`timescale 1ns/1ps
module wdb_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/wdb_afifo.sv
`timescale 1ns/1ps
module wdb_afifo #(
  parameter int W  = 33,
  parameter int AW = 4
) (
  input  logic         wclk_i,
  input  logic         wrst_ni,
  input  logic         wen_i,
  input  logic [W-1:0] wdata_i,
  output logic         wfull_o,
  input  logic         rclk_i,
  input  logic         rrst_ni,
  input  logic         ren_i,
  output logic [W-1:0] rdata_o,
  output logic         rempty_o,
  output logic [AW:0]  rcount_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] rgray_w, wgray_r, wbin_r;
  logic [PW-1:0] wbin_nxt, rbin_nxt;
  logic          push, pop;

  // write domain
  assign push     = wen_i && !wfull_o;
  assign wbin_nxt = wbin_q + PW'(1);
  assign wfull_o  = (wgray_q == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (push) begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  always_ff @(posedge wclk_i) begin
    if (push) mem[wbin_q[AW-1:0]] <= wdata_i;
  end

  wdb_sync #(.W(PW)) u_r2w (
    .clk_i (wclk_i),
    .rst_ni(wrst_ni),
    .d_i   (rgray_q),
    .q_o   (rgray_w)
  );

  // read domain
  wdb_sync #(.W(PW)) u_w2r (
    .clk_i (rclk_i),
    .rst_ni(rrst_ni),
    .d_i   (wgray_q),
    .q_o   (wgray_r)
  );

  always_comb begin
    wbin_r[PW-1] = wgray_r[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin_r[i] = wbin_r[i+1] ^ wgray_r[i];
  end

  assign rcount_o = wbin_r - rbin_q;
  assign rempty_o = (rcount_o == '0);
  assign pop      = ren_i && !rempty_o;
  assign rbin_nxt = rbin_q + PW'(1);
  assign rdata_o  = mem[rbin_q[AW-1:0]];

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (pop) begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end
endmodule

// File: rtl/wdb_release.sv
`timescale 1ns/1ps
module wdb_release
  import wdb_pkg::*;
#(
  parameter int AW = 4,
  parameter int LW = 4,
  parameter int RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ratio_i,
  input  logic          len_empty_i,
  input  logic [LW-1:0] len_i,
  input  logic [AW:0]   fill_i,
  input  logic          data_empty_i,
  input  logic          beat_last_i,
  input  logic          s_wready_i,
  output logic          s_wvalid_o,
  output logic          beat_pop_o,
  output logic          len_pop_o
);
  localparam int DEPTH = 1 << AW;

  logic       open_q;
  logic [7:0] beats, thresh;
  logic       go, done;

  assign beats  = 8'(len_i) + 8'd1;
  assign thresh = squeeze_thresh(beats, 8'(ratio_i));
  // full buffer also releases (covers a burst larger than what can ever gather)
  assign go     = !len_empty_i && ((8'(fill_i) >= thresh) || (fill_i == (AW+1)'(DEPTH)));

  assign s_wvalid_o = open_q && !data_empty_i;
  assign beat_pop_o = s_wvalid_o && s_wready_i;
  assign done       = beat_pop_o && beat_last_i;
  assign len_pop_o  = done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            open_q <= 1'b0;
    else if (done)          open_q <= 1'b0;
    else if (!open_q && go) open_q <= 1'b1;
  end
endmodule

// File: rtl/wdb_squeeze_bridge.sv
`timescale 1ns/1ps
module wdb_squeeze_bridge #(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int LW = 4,
  parameter int RW = 4,
  parameter int QAW = 2
) (
  input  logic          m_clk_i,
  input  logic          m_rst_ni,
  input  logic          m_len_valid_i,
  output logic          m_len_ready_o,
  input  logic [LW-1:0] m_len_i,
  input  logic          m_wvalid_i,
  output logic          m_wready_o,
  input  logic [DW-1:0] m_wdata_i,
  input  logic          m_wlast_i,
  input  logic          s_clk_i,
  input  logic          s_rst_ni,
  input  logic [RW-1:0] ratio_i,
  output logic          s_wvalid_o,
  input  logic          s_wready_i,
  output logic [DW-1:0] s_wdata_o,
  output logic          s_wlast_o
);
  localparam int BW = DW + 1;

  logic          d_full, d_empty, l_full, l_empty;
  logic [BW-1:0] d_rd;
  logic [LW-1:0] l_rd;
  logic [AW:0]   s_fill;
  logic [QAW:0]  l_fill;
  logic          beat_pop, len_pop;

  assign m_wready_o    = !d_full;
  assign m_len_ready_o = !l_full;

  wdb_afifo #(.W(BW), .AW(AW)) u_data_q (
    .wclk_i  (m_clk_i),
    .wrst_ni (m_rst_ni),
    .wen_i   (m_wvalid_i),
    .wdata_i ({m_wlast_i, m_wdata_i}),
    .wfull_o (d_full),
    .rclk_i  (s_clk_i),
    .rrst_ni (s_rst_ni),
    .ren_i   (beat_pop),
    .rdata_o (d_rd),
    .rempty_o(d_empty),
    .rcount_o(s_fill)
  );

  wdb_afifo #(.W(LW), .AW(QAW)) u_len_q (
    .wclk_i  (m_clk_i),
    .wrst_ni (m_rst_ni),
    .wen_i   (m_len_valid_i),
    .wdata_i (m_len_i),
    .wfull_o (l_full),
    .rclk_i  (s_clk_i),
    .rrst_ni (s_rst_ni),
    .ren_i   (len_pop),
    .rdata_o (l_rd),
    .rempty_o(l_empty),
    .rcount_o(l_fill)
  );

  wdb_release #(.AW(AW), .LW(LW), .RW(RW)) u_gate (
    .clk_i       (s_clk_i),
    .rst_ni      (s_rst_ni),
    .ratio_i     (ratio_i),
    .len_empty_i (l_empty),
    .len_i       (l_rd),
    .fill_i      (s_fill),
    .data_empty_i(d_empty),
    .beat_last_i (d_rd[DW]),
    .s_wready_i  (s_wready_i),
    .s_wvalid_o  (s_wvalid_o),
    .beat_pop_o  (beat_pop),
    .len_pop_o   (len_pop)
  );

  assign s_wdata_o = d_rd[DW-1:0];
  assign s_wlast_o = s_wvalid_o && d_rd[DW];

  logic unused_fill;
  assign unused_fill = ^l_fill;
endmodule

// File: rtl/wdb_checker.sv
`timescale 1ns/1ps
module wdb_checker #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          s_clk_i,
  input logic          s_rst_ni,
  input logic          s_wvalid_o,
  input logic          s_wready_i,
  input logic [DW-1:0] s_wdata_o,
  input logic          s_wlast_o,
  input logic [AW:0]   s_fill_i
);
  localparam int DEPTH = 1 << AW;

  assert_no_bubble_R5: assert property (@(posedge s_clk_i) disable iff (!s_rst_ni)
    (s_wvalid_o && s_wready_i && !s_wlast_o) |=> s_wvalid_o);

  assert_gap_after_last_R6: assert property (@(posedge s_clk_i) disable iff (!s_rst_ni)
    (s_wvalid_o && s_wready_i && s_wlast_o) |=> !s_wvalid_o);

  assert_hold_on_stall_R9: assert property (@(posedge s_clk_i) disable iff (!s_rst_ni)
    (s_wvalid_o && !s_wready_i) |=> (s_wvalid_o && $stable(s_wdata_o) && $stable(s_wlast_o)));

  assert_no_overflow_R3: assert property (@(posedge s_clk_i) disable iff (!s_rst_ni)
    s_fill_i <= (AW+1)'(DEPTH));
endmodule

bind wdb_squeeze_bridge wdb_checker #(.DW(DW), .AW(AW)) u_chk (
  .s_clk_i   (s_clk_i),
  .s_rst_ni  (s_rst_ni),
  .s_wvalid_o(s_wvalid_o),
  .s_wready_i(s_wready_i),
  .s_wdata_o (s_wdata_o),
  .s_wlast_o (s_wlast_o),
  .s_fill_i  (s_fill)
);

// File: tb/wdb_squeeze_bridge_tb.sv
`timescale 1ns/1ps
module wdb_squeeze_bridge_tb;
  localparam int DW = 32;

  logic m_clk = 0, s_clk = 0;
  logic m_rst_n = 0, s_rst_n = 0;
  real  m_half = 2.5;

  logic          m_len_valid = 0, m_wvalid = 0, m_wlast = 0;
  logic [3:0]    m_len = 0, ratio = 1;
  logic [DW-1:0] m_wdata = 0;
  logic          m_len_ready, m_wready;
  logic          s_wvalid, s_wready = 0, s_wlast;
  logic [DW-1:0] s_wdata;

  always #2.5 s_clk = ~s_clk;
  always #(m_half) m_clk = ~m_clk;

  wdb_squeeze_bridge u_dut (
    .m_clk_i(m_clk), .m_rst_ni(m_rst_n),
    .m_len_valid_i(m_len_valid), .m_len_ready_o(m_len_ready), .m_len_i(m_len),
    .m_wvalid_i(m_wvalid), .m_wready_o(m_wready), .m_wdata_i(m_wdata), .m_wlast_i(m_wlast),
    .s_clk_i(s_clk), .s_rst_ni(s_rst_n), .ratio_i(ratio),
    .s_wvalid_o(s_wvalid), .s_wready_i(s_wready), .s_wdata_o(s_wdata), .s_wlast_o(s_wlast)
  );

  int n_chk = 0, n_bad = 0;
  logic [DW:0] exp_q[$];
  int len_arr[64];
  int wr_cnt[64];
  int lcnt = 0, dcnt = 0, seed_word = 0;
  int rdy_mode = 0;
  int cur_ratio = 1;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // ---------------- driver ----------------
  task automatic put_len(input int beats);
    m_len_valid = 1; m_len = 4'(beats - 1);
    while (!m_len_ready) @(negedge m_clk);
    @(posedge m_clk);
    len_arr[lcnt] = beats; lcnt++;
    @(negedge m_clk);
    m_len_valid = 0;
  endtask

  task automatic put_data(input int beats, output bit waited);
    int b;
    b = dcnt; dcnt++;
    waited = 0;
    for (int i = 0; i < beats; i++) begin
      m_wvalid = 1;
      m_wdata  = DW'(seed_word) ^ 32'hA5C3_0000;
      m_wlast  = (i == beats - 1);
      while (!m_wready) begin waited = 1; @(negedge m_clk); end
      @(posedge m_clk);
      wr_cnt[b]++;
      exp_q.push_back({m_wlast, m_wdata});
      seed_word++;
      @(negedge m_clk);
    end
    m_wvalid = 0; m_wlast = 0;
  endtask

  task automatic send_burst(input int beats);
    bit w;
    put_len(beats);
    put_data(beats, w);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge s_clk);
    repeat (4) @(negedge s_clk);
  endtask

  task automatic do_reset(input int r);
    m_rst_n = 0; s_rst_n = 0;
    cur_ratio = r; ratio = 4'(r); m_half = 2.5 * r;
    exp_q.delete();
    lcnt = 0; dcnt = 0;
    for (int i = 0; i < 64; i++) begin wr_cnt[i] = 0; len_arr[i] = 0; end
    repeat (4) @(negedge m_clk);
    m_rst_n = 1;
    @(negedge s_clk); s_rst_n = 1;
    repeat (3) @(negedge m_clk);
  endtask

  // ---------------- monitor ----------------
  int  bidx = 0;
  bit  first_done = 0, in_burst = 0, gap_pend = 0;

  always @(negedge s_clk) begin
    if (!s_rst_n) begin
      bidx = 0; first_done = 0; in_burst = 0; gap_pend = 0;
      s_wready = 0;
    end else begin
      if (gap_pend) begin // R6
        check(!s_wvalid, "R6 gap after last", s_wvalid, 0);
        gap_pend = 0;
      end
      if (in_burst) check(s_wvalid, "R5 no bubble", s_wvalid, 1);
      if (s_wvalid && !first_done) begin // R4 release threshold
        int l, t;
        l = len_arr[bidx];
        t = l - (l - 1) / cur_ratio;
        check(wr_cnt[bidx] >= t, "R4 release threshold", wr_cnt[bidx], t);
        first_done = 1;
      end
      case (rdy_mode)
        0: s_wready = 1;
        1: s_wready = ($urandom % 4) != 0;
        default: s_wready = 0;
      endcase
      if (s_wvalid && s_wready) begin // R2 scoreboard
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected beat", {s_wlast, s_wdata}, 0);
        end else begin
          logic [DW:0] e;
          e = exp_q.pop_front();
          check({s_wlast, s_wdata} == e, "R2 data/last order", {s_wlast, s_wdata}, e);
        end
        if (s_wlast) begin
          in_burst = 0; gap_pend = 1; first_done = 0; bidx++;
        end else begin
          in_burst = 1;
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge s_clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- sequence ----------------
  int lens[7] = '{1, 16, 4, 7, 16, 2, 9};

  initial begin
    bit w;
    do_reset(1);
    @(negedge s_clk);
    // R1 reset state
    check(!s_wvalid, "R1 s_wvalid after reset", s_wvalid, 0);
    check(m_wready, "R1 m_wready after reset", m_wready, 1);
    check(m_len_ready, "R1 m_len_ready after reset", m_len_ready, 1);

    // back-to-back bursts, ready always high, several ratios (R2 R4 R5 R6)
    for (int r = 1; r <= 4; r++) begin
      if (r != 1) do_reset(r);
      @(negedge m_clk);
      foreach (lens[i]) send_burst(lens[i]);
      drain();
    end

    // random slave stalls, one burst at a time (R9 hold, R5)
    do_reset(2);
    rdy_mode = 1;
    @(negedge m_clk);
    foreach (lens[i]) begin
      send_burst(lens[i]);
      drain();
    end
    rdy_mode = 0;

    // R3: 16 beats absorbed with slave blocked
    do_reset(3);
    rdy_mode = 2;
    @(negedge m_clk);
    put_len(16);
    put_data(16, w);
    check(!w, "R3 16 beats without wait", w, 0);
    check(!m_wready, "R3 full after 16 beats", m_wready, 0);
    rdy_mode = 0;
    drain();
    @(negedge m_clk);
    check(m_wready, "R3 room after drain", m_wready, 1);

    // R7: length queue depth 4
    do_reset(2);
    rdy_mode = 2;
    @(negedge m_clk);
    for (int i = 0; i < 4; i++) put_len(2);
    check(!m_len_ready, "R7 length queue full", m_len_ready, 0);
    for (int i = 0; i < 4; i++) put_data(2, w);
    rdy_mode = 0;
    drain();
    @(negedge m_clk); @(negedge m_clk);
    check(m_len_ready, "R7 length queue drained", m_len_ready, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule